// File: doc/BRIEF.md
# Integrating Converter Readout Controller

This block sits on the host side of an integrating analog-to-digital converter. The converter keeps accumulating until the host asks for data. It then acknowledges the request on one status line, presents eight bytes one after another on an 8-bit bus, and marks each byte with a strobe on a second status line. The controller drives the request and bus-enable lines and collects the bytes. From them it builds two 32-bit words. The first is the elapsed integration time. The second is the integral of the input, with a fixed bias of 8 removed from its top byte. Both words are presented together with a single-cycle valid pulse.

Both status lines pass through multi-stage synchronizers, and the controller detects strobe edges in its own clock domain. A cycle-count watchdog returns the controller to idle and raises an error flag if the converter stops responding. A separate request issues an auto-zero pulse of a fixed number of clock cycles. The ratio of the two words is left to software.

Top module: `conv_rdout_ctrl`

## Requirements
- R1: After reset, the request, bus-enable and auto-zero outputs are high (inactive). The valid pulse, short flag and timeout flag are low, and both words are zero.
- R2: A one-cycle `start_i` pulse in idle drives `conv_dreq_n_o` low at the next clock edge. The line stays low until the synchronized acknowledge line `conv_s1_i` is seen high, and then it returns high.
- R3: `conv_oe_n_o` is low from the start of a request until the frame ends or times out, and high at all other times. It is always low whenever `conv_dreq_n_o` is low.
- R4: Each synchronized rising edge of `conv_s0_i` captures `conv_data_i` as the next byte. Bytes 1..4 form `time_word_o` with byte 1 in bits 31:24 and byte 4 in bits 7:0.
- R5: Bytes 5..8 form `integ_word_o` in the same big-endian order. Bits 31:24 hold byte 5 minus 8, modulo 256 (byte 5 of 0x03 gives 0xFB).
- R6: Strobe edges after the eighth byte of a frame are ignored and do not change either word.
- R7: The synchronized fall of `conv_s1_i` ends the frame. `result_vld_o` pulses for exactly one cycle, and both words update on that same cycle.
- R8: If fewer than eight bytes arrived before the frame ends, `short_frame_o` is set, and bytes that never arrived read as zero (byte 5 missing gives 0xF8 in bits 31:24 of the integral word).
- R9: A one-cycle `az_req_i` pulse in idle drives `conv_az_n_o` low for exactly AZ_CYCLES cycles (10 by default, which is 100 ns at 100 MHz). It wins over a simultaneous start, and a start issued during auto-zero is ignored.
- R10: If TIMEOUT_CYCLES pass with no acknowledge during the request, or with no strobe edge and no acknowledge fall during capture, `timeout_err_o` is set. The controller then returns to idle with request and enable high and issues no valid pulse.
- R11: `short_frame_o` and `timeout_err_o` hold until the next accepted start or auto-zero request. The two words hold until the next frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse: begin a readout |
| az_req_i | input | 1 | Pulse: issue an auto-zero |
| conv_s0_i | input | 1 | Converter byte strobe (asynchronous) |
| conv_s1_i | input | 1 | Converter acknowledge / frame line (asynchronous) |
| conv_data_i | input | 8 | Converter data bus |
| conv_dreq_n_o | output | 1 | Data request to the converter, active low |
| conv_oe_n_o | output | 1 | Bus output enable to the converter, active low |
| conv_az_n_o | output | 1 | Auto-zero to the converter, active low |
| time_word_o | output | 32 | Assembled integration-time word |
| integ_word_o | output | 32 | Assembled integral word, bias removed |
| result_vld_o | output | 1 | One-cycle pulse: words updated |
| short_frame_o | output | 1 | Last frame ended with fewer than eight bytes |
| timeout_err_o | output | 1 | Last transaction timed out |

## Verification
The hardest state to reach from the ports is a stall in the middle of capture: the acknowledge is already high and some bytes have arrived, but the strobe goes quiet. Only this case shows that the timer restarts on each strobe edge and that a timeout leaves the previously presented words untouched. The bench models the converter as a task that can stop after any byte count while keeping the acknowledge high, and it can also keep strobing after the eighth byte or drop the acknowledge early. Random frames, with random bytes and a random acknowledge delay, are mixed with these directed stalls, over-long frames, short frames and bias-wrap byte values.

// File: rtl/conv_rdout_pkg.sv
package conv_rdout_pkg;

  localparam int unsigned FRAME_BYTES = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CAPT = 2'd2,
    ST_AZ   = 2'd3
  } rd_state_e;

endpackage

// File: rtl/conv_sync_bit.sv
module conv_sync_bit #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/conv_frame_shifter.sv
module conv_frame_shifter #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_BYTES = 8,
  parameter int unsigned BIAS      = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              clear_i,
  input  logic                              cap_i,
  input  logic [BYTE_W-1:0]                 data_i,
  input  logic                              load_i,
  output logic                              full_o,
  output logic [(NUM_BYTES/2)*BYTE_W-1:0]   time_word_o,
  output logic [(NUM_BYTES/2)*BYTE_W-1:0]   integ_word_o
);

  localparam int unsigned HALF   = NUM_BYTES / 2;
  localparam int unsigned WORD_W = HALF * BYTE_W;
  localparam int unsigned CNT_W  = $clog2(NUM_BYTES + 1);

  logic [CNT_W-1:0]  count_q;
  logic              cap_ok;
  logic [WORD_W-1:0] asm_time;
  logic [WORD_W-1:0] asm_integ;
  logic [WORD_W-1:0] time_q;
  logic [WORD_W-1:0] integ_q;
  logic [NUM_BYTES-1:0][BYTE_W-1:0] byte_q;

  assign full_o = (count_q == CNT_W'(NUM_BYTES));
  assign cap_ok = cap_i && !full_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (cap_ok) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[i] <= '0;
      end else if (clear_i) begin
        byte_q[i] <= '0;
      end else if (cap_ok && (count_q == CNT_W'(i))) begin
        byte_q[i] <= data_i;
      end
    end
  end

  for (genvar i = 0; i < HALF; i++) begin : g_asm
    assign asm_time[(HALF-1-i)*BYTE_W +: BYTE_W] = byte_q[i];
    if (i == 0) begin : g_bias
      assign asm_integ[(HALF-1)*BYTE_W +: BYTE_W] = byte_q[HALF] - BYTE_W'(BIAS);
    end else begin : g_plain
      assign asm_integ[(HALF-1-i)*BYTE_W +: BYTE_W] = byte_q[HALF+i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q  <= '0;
      integ_q <= '0;
    end else if (load_i) begin
      time_q  <= asm_time;
      integ_q <= asm_integ;
    end
  end

  assign time_word_o  = time_q;
  assign integ_word_o = integ_q;

endmodule

// File: rtl/conv_rdout_fsm.sv
module conv_rdout_fsm
  import conv_rdout_pkg::*;
#(
  parameter int unsigned AZ_CYCLES      = 10,
  parameter int unsigned TIMEOUT_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic az_req_i,
  input  logic s1_i,
  input  logic s0_rise_i,
  input  logic frame_full_i,
  output logic dreq_n_o,
  output logic oe_n_o,
  output logic az_n_o,
  output logic clear_o,
  output logic load_o,
  output logic result_vld_o,
  output logic short_frame_o,
  output logic timeout_err_o
);

  localparam int unsigned TO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int unsigned AZ_W = $clog2(AZ_CYCLES + 1);

  rd_state_e       state_q, state_d;
  logic [TO_W-1:0] to_cnt_q, to_cnt_d;
  logic [AZ_W-1:0] az_cnt_q, az_cnt_d;
  logic            to_fire;
  logic            accept;
  logic            to_evt;
  logic            dreq_n_q, oe_n_q, az_n_q, vld_q, short_q, tout_q;

  assign to_fire = (to_cnt_q == TO_W'(TIMEOUT_CYCLES - 1));

  always_comb begin
    state_d = state_q;
    clear_o = 1'b0;
    load_o  = 1'b0;
    accept  = 1'b0;
    to_evt  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (az_req_i) begin
          state_d = ST_AZ;
          accept  = 1'b1;
        end else if (start_i) begin
          state_d = ST_REQ;
          clear_o = 1'b1;
          accept  = 1'b1;
        end
      end
      ST_REQ: begin
        if (s1_i) begin
          state_d = ST_CAPT;
        end else if (to_fire) begin
          state_d = ST_IDLE;
          to_evt  = 1'b1;
        end
      end
      ST_CAPT: begin
        if (!s1_i) begin
          state_d = ST_IDLE;
          load_o  = 1'b1;
        end else if (to_fire) begin
          state_d = ST_IDLE;
          to_evt  = 1'b1;
        end
      end
      ST_AZ: begin
        if (az_cnt_q == AZ_W'(AZ_CYCLES - 1)) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if ((state_q == ST_IDLE) || (state_d != state_q) || s0_rise_i) begin
      to_cnt_d = '0;
    end else begin
      to_cnt_d = to_cnt_q + TO_W'(1);
    end
    if (state_q == ST_AZ) begin
      az_cnt_d = az_cnt_q + AZ_W'(1);
    end else begin
      az_cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      to_cnt_q <= '0;
      az_cnt_q <= '0;
      dreq_n_q <= 1'b1;
      oe_n_q   <= 1'b1;
      az_n_q   <= 1'b1;
      vld_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      to_cnt_q <= to_cnt_d;
      az_cnt_q <= az_cnt_d;
      dreq_n_q <= (state_d != ST_REQ);
      oe_n_q   <= !((state_d == ST_REQ) || (state_d == ST_CAPT));
      az_n_q   <= (state_d != ST_AZ);
      vld_q    <= load_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_q <= 1'b0;
      tout_q  <= 1'b0;
    end else begin
      if (accept) begin
        short_q <= 1'b0;
      end else if (load_o) begin
        short_q <= !frame_full_i;
      end
      if (accept) begin
        tout_q <= 1'b0;
      end else if (to_evt) begin
        tout_q <= 1'b1;
      end
    end
  end

  assign dreq_n_o      = dreq_n_q;
  assign oe_n_o        = oe_n_q;
  assign az_n_o        = az_n_q;
  assign result_vld_o  = vld_q;
  assign short_frame_o = short_q;
  assign timeout_err_o = tout_q;

endmodule

// File: rtl/conv_rdout_ctrl.sv
module conv_rdout_ctrl #(
  parameter int unsigned BYTE_W         = 8,
  parameter int unsigned NUM_BYTES      = conv_rdout_pkg::FRAME_BYTES,
  parameter int unsigned BYTE_BIAS      = 8,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned AZ_CYCLES      = 10,
  parameter int unsigned TIMEOUT_CYCLES = 4096
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic                            az_req_i,
  input  logic                            conv_s0_i,
  input  logic                            conv_s1_i,
  input  logic [BYTE_W-1:0]               conv_data_i,
  output logic                            conv_dreq_n_o,
  output logic                            conv_oe_n_o,
  output logic                            conv_az_n_o,
  output logic [(NUM_BYTES/2)*BYTE_W-1:0] time_word_o,
  output logic [(NUM_BYTES/2)*BYTE_W-1:0] integ_word_o,
  output logic                            result_vld_o,
  output logic                            short_frame_o,
  output logic                            timeout_err_o
);

  localparam int unsigned N_STAT = 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [N_STAT-1:0] stat_raw;
  logic [N_STAT-1:0] stat_sync;
  logic              s0_q;
  logic              s0_rise;
  logic              clear;
  logic              load;
  logic              full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  assign stat_raw = {conv_s1_i, conv_s0_i};

  for (genvar g = 0; g < N_STAT; g++) begin : g_sync
    conv_sync_bit #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_int_n),
      .d_i   (stat_raw[g]),
      .q_o   (stat_sync[g])
    );
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      s0_q <= 1'b0;
    end else begin
      s0_q <= stat_sync[0];
    end
  end
  assign s0_rise = stat_sync[0] && !s0_q;

  conv_rdout_fsm #(
    .AZ_CYCLES      (AZ_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .start_i       (start_i),
    .az_req_i      (az_req_i),
    .s1_i          (stat_sync[1]),
    .s0_rise_i     (s0_rise),
    .frame_full_i  (full),
    .dreq_n_o      (conv_dreq_n_o),
    .oe_n_o        (conv_oe_n_o),
    .az_n_o        (conv_az_n_o),
    .clear_o       (clear),
    .load_o        (load),
    .result_vld_o  (result_vld_o),
    .short_frame_o (short_frame_o),
    .timeout_err_o (timeout_err_o)
  );

  conv_frame_shifter #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (NUM_BYTES),
    .BIAS      (BYTE_BIAS)
  ) u_shift (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .clear_i      (clear),
    .cap_i        (s0_rise && !conv_oe_n_o && !stat_sync[1] == 1'b0),
    .data_i       (conv_data_i),
    .load_i       (load),
    .full_o       (full),
    .time_word_o  (time_word_o),
    .integ_word_o (integ_word_o)
  );

endmodule

// File: rtl/conv_rdout_chk.sv
module conv_rdout_chk #(
  parameter int unsigned AZ_CYCLES = 10
) (
  input logic clk,
  input logic rst_n,
  input logic dreq_n,
  input logic oe_n,
  input logic az_n,
  input logic result_vld,
  input logic timeout_err
);

  localparam int unsigned RUN_W = $clog2(AZ_CYCLES + 2);

  logic [RUN_W-1:0] az_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      az_run_q <= '0;
    end else if (!az_n) begin
      az_run_q <= az_run_q + RUN_W'(1);
    end else begin
      az_run_q <= '0;
    end
  end

  p_oe_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dreq_n |-> !oe_n);

  p_vld_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> !result_vld);

  p_no_req_in_az_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !az_n |-> dreq_n);

  p_az_not_long_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !az_n |-> (az_run_q < RUN_W'(AZ_CYCLES)));

  p_az_exact_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(az_n) |-> (az_run_q == RUN_W'(AZ_CYCLES)));

  p_timeout_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (dreq_n && oe_n && !result_vld));

endmodule

bind conv_rdout_ctrl conv_rdout_chk #(.AZ_CYCLES(AZ_CYCLES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .dreq_n      (conv_dreq_n_o),
  .oe_n        (conv_oe_n_o),
  .az_n        (conv_az_n_o),
  .result_vld  (result_vld_o),
  .timeout_err (timeout_err_o)
);

// File: tb/conv_rdout_ctrl_tb_top.sv
module conv_rdout_ctrl_tb_top;

  localparam int TO_CYC = 300;
  localparam int AZ_CYC = 10;

  logic        clk;
  logic        rst_n;
  logic        start_i, az_req_i, s0, s1;
  logic [7:0]  data;
  logic        dreq_n, oe_n, az_n, vld, short_f, tout;
  logic [31:0] time_w, integ_w;

  int n_chk, n_err;
  logic [7:0]  fb [0:9];
  logic [31:0] held_time, held_integ;

  conv_rdout_ctrl #(.AZ_CYCLES(AZ_CYC), .TIMEOUT_CYCLES(TO_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .az_req_i(az_req_i),
    .conv_s0_i(s0), .conv_s1_i(s1), .conv_data_i(data),
    .conv_dreq_n_o(dreq_n), .conv_oe_n_o(oe_n), .conv_az_n_o(az_n),
    .time_word_o(time_w), .integ_word_o(integ_w), .result_vld_o(vld),
    .short_frame_o(short_f), .timeout_err_o(tout)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int idx, input int nb);
    return (idx < nb) ? fb[idx] : 8'h00;
  endfunction

  function automatic logic [31:0] exp_time(input int nb);
    return {bval(0, nb), bval(1, nb), bval(2, nb), bval(3, nb)};
  endfunction

  function automatic logic [31:0] exp_integ(input int nb);
    logic [7:0] top;
    top = bval(4, nb) - 8'd8;
    return {top, bval(5, nb), bval(6, nb), bval(7, nb)};
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) data = b;
    repeat (2) @(negedge clk);
    s0 = 1'b1;
    repeat (4) @(negedge clk);
    s0 = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  // nb bytes sent, then S1 dropped; words expected from the first min(nb,8)
  task automatic do_frame(input int nb, input string tag);
    int dly;
    bit seen;
    int used;
    used = (nb > 8) ? 8 : nb;
    pulse_start();
    chk(dreq_n == 1'b0, "R2 request low after start", {31'd0, dreq_n}, 32'd0);
    dly = $urandom_range(15, 3);
    repeat (dly) @(negedge clk);
    chk(dreq_n == 1'b0 && oe_n == 1'b0, "R2/R3 low while awaiting ack", {30'd0, dreq_n, oe_n}, 32'd0);
    s1 = 1'b1;
    repeat (6) @(negedge clk);
    chk(dreq_n == 1'b1, "R2 request released after ack", {31'd0, dreq_n}, 32'd1);
    chk(oe_n == 1'b0, "R3 enable low in capture", {31'd0, oe_n}, 32'd0);
    for (int i = 0; i < nb; i++) send_byte(fb[i]);
    s1 = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 10 && !seen; i++) begin
      @(negedge clk);
      if (vld) seen = 1'b1;
    end
    chk(seen, {"R7 valid pulse ", tag}, {31'd0, seen}, 32'd1);
    chk(time_w == exp_time(used), {"R4 time word ", tag}, time_w, exp_time(used));
    chk(integ_w == exp_integ(used), {"R5 integral word ", tag}, integ_w, exp_integ(used));
    chk(short_f == (nb < 8), {"R8 short flag ", tag}, {31'd0, short_f}, {31'd0, nb < 8});
    @(negedge clk);
    chk(vld == 1'b0, "R7 valid lasts one cycle", {31'd0, vld}, 32'd0);
    chk(oe_n == 1'b1, "R3 enable high after frame", {31'd0, oe_n}, 32'd1);
    held_time  = exp_time(used);
    held_integ = exp_integ(used);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk + 1, n_err);
    $finish;
  end

  initial begin
    int low_cnt;
    bit req_seen, vseen;
    n_chk = 0; n_err = 0;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; start_i = 1'b0; az_req_i = 1'b0;
    s0 = 1'b0; s1 = 1'b0; data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(dreq_n && oe_n && az_n, "R1 pins inactive", {29'd0, dreq_n, oe_n, az_n}, 32'd7);
    chk(!vld && !short_f && !tout, "R1 flags low", {29'd0, vld, short_f, tout}, 32'd0);
    chk(time_w == 0 && integ_w == 0, "R1 words zero", time_w | integ_w, 32'd0);

    // R4/R5 directed: bias exactly 8 -> top byte zero
    fb[0] = 8'h00; fb[1] = 8'h00; fb[2] = 8'h12; fb[3] = 8'h34;
    fb[4] = 8'h08; fb[5] = 8'hAB; fb[6] = 8'hCD; fb[7] = 8'hEF;
    do_frame(8, "bias8");
    // R5 wrap: byte5 = 0x03 -> 0xFB
    fb[0] = 8'hFF; fb[1] = 8'h80; fb[2] = 8'h01; fb[3] = 8'h7E;
    fb[4] = 8'h03; fb[5] = 8'h00; fb[6] = 8'hFF; fb[7] = 8'h5A;
    do_frame(8, "wrap");

    // random frames
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < 8; i++) fb[i] = 8'($urandom_range(255, 0));
      do_frame(8, "random");
    end

    // R6 extra strobes ignored
    for (int i = 0; i < 10; i++) fb[i] = 8'($urandom_range(255, 0));
    do_frame(10, "R6 extra bytes");

    // R8 short frame of 5 bytes, then R11 flag cleared by a full frame
    for (int i = 0; i < 8; i++) fb[i] = 8'($urandom_range(255, 0));
    do_frame(5, "short5");
    chk(short_f == 1'b1, "R11 short flag held", {31'd0, short_f}, 32'd1);
    do_frame(3, "short3 byte5 missing");
    do_frame(8, "full after short");

    // R9 auto-zero wins over simultaneous start; later start ignored
    @(negedge clk) begin az_req_i = 1'b1; start_i = 1'b1; end
    @(negedge clk) begin az_req_i = 1'b0; start_i = 1'b0; end
    low_cnt = 0; req_seen = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (!az_n) low_cnt++;
      if (!dreq_n) req_seen = 1'b1;
      if (i == 3) start_i = 1'b1;
      if (i == 4) start_i = 1'b0;
      @(negedge clk);
    end
    chk(low_cnt == AZ_CYC, "R9 auto-zero width", low_cnt, AZ_CYC);
    chk(!req_seen, "R9 start ignored during auto-zero", {31'd0, req_seen}, 32'd0);

    // R10 timeout with no acknowledge
    pulse_start();
    vseen = 1'b0;
    for (int i = 0; i < TO_CYC + 20; i++) begin
      @(negedge clk);
      if (vld) vseen = 1'b1;
    end
    chk(tout == 1'b1, "R10 timeout flag, no ack", {31'd0, tout}, 32'd1);
    chk(dreq_n && oe_n, "R10 lines released", {30'd0, dreq_n, oe_n}, 32'd3);
    chk(!vseen, "R10 no valid on timeout", {31'd0, vseen}, 32'd0);

    // R10 stall mid capture: 3 bytes then silence with ack high
    pulse_start();
    chk(tout == 1'b0, "R11 timeout cleared by start", {31'd0, tout}, 32'd0);
    repeat (5) @(negedge clk);
    s1 = 1'b1;
    for (int i = 0; i < 3; i++) send_byte(8'($urandom_range(255, 0)));
    vseen = 1'b0;
    for (int i = 0; i < TO_CYC + 20; i++) begin
      @(negedge clk);
      if (vld) vseen = 1'b1;
    end
    chk(tout == 1'b1, "R10 timeout flag, stalled capture", {31'd0, tout}, 32'd1);
    chk(oe_n == 1'b1, "R10 enable released", {31'd0, oe_n}, 32'd1);
    chk(!vseen, "R10 no valid after stall", {31'd0, vseen}, 32'd0);
    chk(time_w == held_time && integ_w == held_integ, "R11 words held over timeout",
        time_w ^ held_time ^ integ_w ^ held_integ, 32'd0);
    s1 = 1'b0;
    repeat (10) @(negedge clk);
    chk(tout == 1'b1, "R11 timeout flag held", {31'd0, tout}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule